// File: doc/BRIEF.md
# Ping-Pong Bulk Endpoint Buffer

This block is the data store that sits between a USB serial interface engine and a local controller or DMA port on a bulk endpoint. It holds two equal banks and works in one direction at a time. In receive direction the USB side writes packets into one bank while the local side reads and frees the other. In transmit direction the local side writes a bank and commits its length. The USB side may send that bank only after the local controller has checked the contents and released the bank. The USB side always takes the banks in strict alternation, starting with bank 0.

Each bank keeps a byte count and a full flag, and in transmit direction a release flag. The largest packet allowed depends on the bus speed selected by `hs_mode`. A received packet longer than that limit is rejected with a one-cycle error pulse. A commit longer than the limit is ignored. Changing direction empties both banks and drops every release. A copy engine can stream the committed contents of any bank out of a separate byte port, so a bank can serve as staging for a media-to-media copy.

Top module: `bulk_pingpong_buf`

## Requirements
- R1: After reset both banks are empty (`bank_full` = 00), `usb_bank` = 0, `usb_rx_ready` = 1, `usb_tx_avail` = 0 and `cp_valid` = 0. The buffer starts in receive direction (`mode_tx` = 0 is receive, 1 is transmit).
- R2: In receive direction, a packet of N bytes, with N at most the speed limit, ends on the byte that has `usb_wr_last` = 1. At that clock edge the bank at `usb_bank` becomes full with count N and `usb_bank` toggles. Byte i of the packet is stored at address i, and the local port reads it back: `loc_rdata` shows bank `loc_bank`, address `loc_addr` one cycle later.
- R3: While the bank at `usb_bank` is full in receive direction, `usb_rx_ready` = 0. Incoming bytes are dropped, and neither the counts nor the stored data of either bank change.
- R4: The speed limit is FS_MAX when `hs_mode` = 0 and HS_MAX when `hs_mode` = 1 (64 and 512 by default). A received packet longer than the limit raises `usb_rx_err` for exactly one cycle after its last byte. Its bank stays empty with count 0, and `usb_bank` does not change.
- R5: In receive direction, `loc_free` empties bank `loc_bank`, clearing both its full flag and its count, so that the bank can be filled again.
- R6: In transmit direction, `loc_commit` with `loc_len` marks bank `loc_bank` full with that count. The bank is not offered (`usb_tx_avail` stays 0) until `loc_release` is given for it.
- R7: In transmit direction, only the bank at `usb_bank` is ever offered, even when the other bank is released. Each `usb_rd_en` returns the next byte, from address 0 upward, on `usb_rd_data` one cycle later. `usb_tx_done` empties the offered bank and toggles `usb_bank`.
- R8: A commit whose `loc_len` exceeds the speed limit of R4 has no effect.
- R9: A `loc_release` given to a bank that is not full has no effect. A later commit to that bank still waits for its own release.
- R10: When `mode_tx` differs from the current direction, the next clock edge switches direction, empties both banks, clears all release flags and sets `usb_bank` to 0.
- R11: `copy_start` on a non-empty bank `loc_bank` streams its count of bytes in address order, one per cycle. The stream begins two cycles after the start: `cp_valid` = 1, `cp_data` carries each byte, and `cp_last` = 1 on the final byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_tx | input | 1 | Direction: 0 receive, 1 transmit |
| hs_mode | input | 1 | Bus speed: 1 selects the high-speed packet limit |
| usb_wr_valid | input | 1 | Received byte strobe |
| usb_wr_data | input | DW | Received byte |
| usb_wr_last | input | 1 | Marks the final byte of a received packet |
| usb_rx_ready | output | 1 | Current USB bank can accept a packet |
| usb_rx_err | output | 1 | One-cycle pulse: received packet exceeded the limit |
| usb_tx_avail | output | 1 | Current USB bank is full and released for sending |
| usb_tx_len | output | CW | Byte count of the current USB bank |
| usb_rd_en | input | 1 | Fetch next byte of the offered bank |
| usb_rd_data | output | DW | Fetched byte, valid the cycle after usb_rd_en |
| usb_tx_done | input | 1 | Offered packet has been sent |
| usb_bank | output | 1 | Bank the USB side is using |
| loc_bank | input | 1 | Bank selected by the local side |
| loc_addr | input | AW | Local byte address |
| loc_wr_en | input | 1 | Local byte write |
| loc_wdata | input | DW | Local write byte |
| loc_rdata | output | DW | Local read byte, one cycle after address |
| loc_commit | input | 1 | Mark selected bank full (transmit) |
| loc_len | input | CW | Byte count for a commit |
| loc_release | input | 1 | Release selected bank for sending |
| loc_free | input | 1 | Empty selected bank (receive) |
| loc_count | output | CW | Byte count of the selected bank |
| bank_full | output | 2 | Full flag of each bank |
| copy_start | input | 1 | Start streaming the selected bank |
| cp_valid | output | 1 | Copy stream byte valid |
| cp_data | output | DW | Copy stream byte |
| cp_last | output | 1 | Final byte of the copy stream |

## Verification
The bench builds the block with 16-byte banks, a full-speed limit of 8 and a high-speed limit of 16. With these sizes a packet exactly at the limit, one byte over each limit, a packet that fills a whole bank and one that would run past the bank end take only tens of cycles each. Full-speed and high-speed limits differ, so the same 9-byte length is legal under one setting and rejected under the other, both for received packets and for commits.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  typedef struct packed {
    logic flush;
    logic clear;
    logic load;
    logic release_req;
  } bank_cmd_t;

endpackage

// File: rtl/pp_bank_ctrl.sv
module pp_bank_ctrl
  import pp_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bank_cmd_t     cmd,
  input  logic [CW-1:0] load_len,
  output logic          full,
  output logic          released,
  output logic [CW-1:0] count
);

  logic          full_q, full_n;
  logic          rel_q, rel_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    full_n = full_q;
    rel_n  = rel_q;
    cnt_n  = cnt_q;
    if (cmd.flush || cmd.clear) begin
      full_n = 1'b0;
      rel_n  = 1'b0;
      cnt_n  = '0;
    end else if (cmd.load) begin
      full_n = 1'b1;
      rel_n  = 1'b0;
      cnt_n  = load_len;
    end else if (cmd.release_req && full_q) begin
      rel_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      rel_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      full_q <= full_n;
      rel_q  <= rel_n;
      cnt_q  <= cnt_n;
    end
  end

  assign full     = full_q;
  assign released = rel_q;
  assign count    = cnt_q;

  // R9
  rel_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> full_q);

  // R10
  flush_clears_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.flush |=> (!full_q && !rel_q && cnt_q == '0));

endmodule

// File: rtl/pp_store.sv
module pp_store #(
  parameter int DW  = 8,
  parameter int IW  = 10,
  parameter int NRD = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wa_en,
  input  logic [IW-1:0]            wa_idx,
  input  logic [DW-1:0]            wa_data,
  input  logic                     wb_en,
  input  logic [IW-1:0]            wb_idx,
  input  logic [DW-1:0]            wb_data,
  input  logic [NRD-1:0]           rd_en,
  input  logic [NRD-1:0][IW-1:0]   rd_idx,
  output logic [NRD-1:0][DW-1:0]   rd_data
);

  localparam int WORDS = 1 << IW;

  logic [DW-1:0] mem [WORDS];
  logic          wb_clash;

  assign wb_clash = wa_en && (wa_idx == wb_idx);

  always_ff @(posedge clk) begin
    if (wa_en) begin
      mem[wa_idx] <= wa_data;
    end
    if (wb_en && !wb_clash) begin
      mem[wb_idx] <= wb_data;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (rd_en[k]) begin
        q <= mem[rd_idx[k]];
      end
    end
    assign rd_data[k] = q;
  end

endmodule

// File: rtl/pp_copy_stream.sv
module pp_copy_stream #(
  parameter int CW = 10,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          start,
  input  logic          start_bank,
  input  logic [CW-1:0] start_len,
  output logic          rd_en,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          cp_valid,
  output logic          cp_last
);

  logic          busy_q, busy_n;
  logic          bank_q, bank_n;
  logic [CW-1:0] len_q, len_n;
  logic [CW-1:0] idx_q, idx_n;
  logic          valid_q, last_q;
  logic          at_end;

  assign at_end = (idx_q == len_q - 1'b1);

  always_comb begin
    busy_n = busy_q;
    bank_n = bank_q;
    len_n  = len_q;
    idx_n  = idx_q;
    if (flush) begin
      busy_n = 1'b0;
      idx_n  = '0;
    end else if (!busy_q) begin
      if (start && (start_len != '0)) begin
        busy_n = 1'b1;
        bank_n = start_bank;
        len_n  = start_len;
        idx_n  = '0;
      end
    end else begin
      idx_n = idx_q + 1'b1;
      if (at_end) begin
        busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      bank_q  <= 1'b0;
      len_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      bank_q  <= bank_n;
      len_q   <= len_n;
      idx_q   <= idx_n;
      valid_q <= busy_q;
      last_q  <= busy_q && at_end;
    end
  end

  assign rd_en    = busy_q;
  assign rd_bank  = bank_q;
  assign rd_addr  = idx_q[AW-1:0];
  assign cp_valid = valid_q;
  assign cp_last  = last_q;

  // R11
  cp_last_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_last |-> cp_valid);

  // R11
  cp_ends_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_last && !busy_q) |=> !cp_valid);

endmodule

// File: rtl/bulk_pingpong_buf.sv
module bulk_pingpong_buf
  import pp_pkg::*;
#(
  parameter int BANK_BYTES = 512,
  parameter int FS_MAX     = 64,
  parameter int HS_MAX     = 512,
  parameter int DW         = 8,
  localparam int AW        = $clog2(BANK_BYTES),
  localparam int CW        = $clog2(BANK_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_tx,
  input  logic          hs_mode,
  input  logic          usb_wr_valid,
  input  logic [DW-1:0] usb_wr_data,
  input  logic          usb_wr_last,
  output logic          usb_rx_ready,
  output logic          usb_rx_err,
  output logic          usb_tx_avail,
  output logic [CW-1:0] usb_tx_len,
  input  logic          usb_rd_en,
  output logic [DW-1:0] usb_rd_data,
  input  logic          usb_tx_done,
  output logic          usb_bank,
  input  logic          loc_bank,
  input  logic [AW-1:0] loc_addr,
  input  logic          loc_wr_en,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  input  logic          loc_commit,
  input  logic [CW-1:0] loc_len,
  input  logic          loc_release,
  input  logic          loc_free,
  output logic [CW-1:0] loc_count,
  output logic [1:0]    bank_full,
  input  logic          copy_start,
  output logic          cp_valid,
  output logic [DW-1:0] cp_data,
  output logic          cp_last
);

  localparam int NB  = 2;
  localparam int IW  = AW + 1;
  localparam int NRD = 3;
  localparam logic [CW-1:0] FS_LIM = CW'(FS_MAX);
  localparam logic [CW-1:0] HS_LIM = CW'(HS_MAX);

  // per-bank state
  logic [NB-1:0] full, rel;
  logic [CW-1:0] cnt [NB];

  // direction and USB-side state
  dir_e          mode_q, mode_n;
  logic          ub_q, ub_n;
  logic [CW-1:0] wcnt_q, wcnt_n;
  logic          ovf_q, ovf_n;
  logic [AW-1:0] rdptr_q, rdptr_n;
  logic          err_q, err_n;

  logic          flush, is_rx, is_tx;
  logic [CW-1:0] max_pkt;
  logic          rx_take, rx_room, rx_store, rx_end, rx_bad;
  logic          rx_good_end, rx_bad_end;
  logic [CW-1:0] rx_len;
  logic          tx_rd, tx_end, commit_ok;

  // copy engine wiring
  logic          cp_rd_en, cp_rd_bank;
  logic [AW-1:0] cp_rd_addr;

  // storage wiring
  logic [NRD-1:0]         st_rd_en;
  logic [NRD-1:0][IW-1:0] st_rd_idx;
  logic [NRD-1:0][DW-1:0] st_rd_data;

  assign flush   = (mode_tx != mode_q);
  assign is_rx   = !flush && (mode_q == DIR_RX);
  assign is_tx   = !flush && (mode_q == DIR_TX);
  assign max_pkt = hs_mode ? HS_LIM : FS_LIM;

  // receive path
  assign rx_take     = is_rx && usb_wr_valid && !full[ub_q];
  assign rx_room     = (wcnt_q < max_pkt);
  assign rx_store    = rx_take && rx_room;
  assign rx_end      = rx_take && usb_wr_last;
  assign rx_bad      = ovf_q || !rx_room;
  assign rx_good_end = rx_end && !rx_bad;
  assign rx_bad_end  = rx_end && rx_bad;
  assign rx_len      = wcnt_q + 1'b1;

  // transmit path
  assign usb_tx_avail = (mode_q == DIR_TX) && full[ub_q] && rel[ub_q];
  assign tx_rd        = usb_rd_en && usb_tx_avail && !flush;
  assign tx_end       = usb_tx_done && usb_tx_avail && !flush;
  assign commit_ok    = is_tx && loc_commit && (loc_len <= max_pkt);

  always_comb begin
    mode_n  = mode_q;
    ub_n    = ub_q;
    wcnt_n  = wcnt_q;
    ovf_n   = ovf_q;
    rdptr_n = rdptr_q;
    err_n   = rx_bad_end;
    if (flush) begin
      mode_n  = dir_e'(mode_tx);
      ub_n    = 1'b0;
      wcnt_n  = '0;
      ovf_n   = 1'b0;
      rdptr_n = '0;
    end else begin
      if (rx_end) begin
        wcnt_n = '0;
        ovf_n  = 1'b0;
      end else if (rx_store) begin
        wcnt_n = wcnt_q + 1'b1;
      end else if (rx_take) begin
        ovf_n  = 1'b1;
      end
      if (tx_end) begin
        rdptr_n = '0;
      end else if (tx_rd) begin
        rdptr_n = rdptr_q + 1'b1;
      end
      if (rx_good_end || tx_end) begin
        ub_n = ~ub_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= DIR_RX;
      ub_q    <= 1'b0;
      wcnt_q  <= '0;
      ovf_q   <= 1'b0;
      rdptr_q <= '0;
      err_q   <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      ub_q    <= ub_n;
      wcnt_q  <= wcnt_n;
      ovf_q   <= ovf_n;
      rdptr_q <= rdptr_n;
      err_q   <= err_n;
    end
  end

  // bank state machines
  for (genvar b = 0; b < NB; b++) begin : g_bank
    bank_cmd_t     cmd;
    logic          sel_loc, sel_usb;
    logic [CW-1:0] ld_len;

    assign sel_loc         = (loc_bank == 1'(b));
    assign sel_usb         = (ub_q == 1'(b));
    assign cmd.flush       = flush;
    assign cmd.clear       = (is_rx && loc_free && sel_loc) || (tx_end && sel_usb);
    assign cmd.load        = (rx_good_end && sel_usb) || (commit_ok && sel_loc);
    assign cmd.release_req = is_tx && loc_release && sel_loc;
    assign ld_len          = is_rx ? rx_len : loc_len;

    pp_bank_ctrl #(.CW(CW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .load_len (ld_len),
      .full     (full[b]),
      .released (rel[b]),
      .count    (cnt[b])
    );
  end

  // copy engine
  pp_copy_stream #(.CW(CW), .AW(AW)) u_copy (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .start      (copy_start && !flush),
    .start_bank (loc_bank),
    .start_len  (cnt[loc_bank]),
    .rd_en      (cp_rd_en),
    .rd_bank    (cp_rd_bank),
    .rd_addr    (cp_rd_addr),
    .cp_valid   (cp_valid),
    .cp_last    (cp_last)
  );

  // shared byte storage: port 0 local, port 1 USB, port 2 copy
  assign st_rd_en[0]  = 1'b1;
  assign st_rd_idx[0] = {loc_bank, loc_addr};
  assign st_rd_en[1]  = tx_rd;
  assign st_rd_idx[1] = {ub_q, rdptr_q};
  assign st_rd_en[2]  = cp_rd_en;
  assign st_rd_idx[2] = {cp_rd_bank, cp_rd_addr};

  pp_store #(.DW(DW), .IW(IW), .NRD(NRD)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (rx_store),
    .wa_idx  ({ub_q, wcnt_q[AW-1:0]}),
    .wa_data (usb_wr_data),
    .wb_en   (loc_wr_en),
    .wb_idx  ({loc_bank, loc_addr}),
    .wb_data (loc_wdata),
    .rd_en   (st_rd_en),
    .rd_idx  (st_rd_idx),
    .rd_data (st_rd_data)
  );

  assign usb_rx_ready = (mode_q == DIR_RX) && !full[ub_q];
  assign usb_rx_err   = err_q;
  assign usb_tx_len   = cnt[ub_q];
  assign usb_rd_data  = st_rd_data[1];
  assign usb_bank     = ub_q;
  assign loc_rdata    = st_rd_data[0];
  assign loc_count    = cnt[loc_bank];
  assign bank_full    = full;
  assign cp_data      = st_rd_data[2];

  // R4
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_rx_err |=> !usb_rx_err);

  // R4
  err_bank_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_rx_err |-> !bank_full[usb_bank]);

  // R3
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_wr_valid && !usb_rx_ready && mode_q == DIR_RX && !flush && !loc_free)
      |=> $stable(bank_full));

  // R7
  tx_done_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_tx_done && usb_tx_avail && !flush) |=> (usb_bank != $past(usb_bank)));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (bank_full == 2'b00 && !usb_bank && !usb_tx_avail));

endmodule

// File: tb/bulk_pingpong_buf_tb_top.sv
`timescale 1ns/1ps
module bulk_pingpong_buf_tb_top;

  localparam int BB = 16;
  localparam int FSM = 8;
  localparam int HSM = 16;
  localparam int AW = 4;
  localparam int CW = 5;

  logic clk, rst_n;
  logic mode_tx, hs_mode;
  logic usb_wr_valid, usb_wr_last;
  logic [7:0] usb_wr_data;
  logic usb_rx_ready, usb_rx_err, usb_tx_avail;
  logic [CW-1:0] usb_tx_len;
  logic usb_rd_en, usb_tx_done, usb_bank;
  logic [7:0] usb_rd_data;
  logic loc_bank, loc_wr_en, loc_commit, loc_release, loc_free;
  logic [AW-1:0] loc_addr;
  logic [7:0] loc_wdata, loc_rdata;
  logic [CW-1:0] loc_len, loc_count;
  logic [1:0] bank_full;
  logic copy_start, cp_valid, cp_last;
  logic [7:0] cp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bit15 high speed, bit14 error expected, bits 7:0 packet length
  localparam logic [15:0] VEC [6] = '{16'h0001, 16'h0008, 16'h4009,
                                      16'h8010, 16'hC011, 16'h8009};

  bulk_pingpong_buf #(.BANK_BYTES(BB), .FS_MAX(FSM), .HS_MAX(HSM)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .hs_mode(hs_mode),
    .usb_wr_valid(usb_wr_valid), .usb_wr_data(usb_wr_data), .usb_wr_last(usb_wr_last),
    .usb_rx_ready(usb_rx_ready), .usb_rx_err(usb_rx_err), .usb_tx_avail(usb_tx_avail),
    .usb_tx_len(usb_tx_len), .usb_rd_en(usb_rd_en), .usb_rd_data(usb_rd_data),
    .usb_tx_done(usb_tx_done), .usb_bank(usb_bank), .loc_bank(loc_bank),
    .loc_addr(loc_addr), .loc_wr_en(loc_wr_en), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .loc_commit(loc_commit), .loc_len(loc_len),
    .loc_release(loc_release), .loc_free(loc_free), .loc_count(loc_count),
    .bank_full(bank_full), .copy_start(copy_start), .cp_valid(cp_valid),
    .cp_data(cp_data), .cp_last(cp_last)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      usb_wr_valid = 1;
      usb_wr_data  = 8'(base + i);
      usb_wr_last  = (i == len - 1);
      step();
    end
    usb_wr_valid = 0;
    usb_wr_last  = 0;
  endtask

  task automatic loc_write(input int b, input int a, input int d);
    loc_bank = b[0]; loc_addr = 4'(a); loc_wdata = 8'(d); loc_wr_en = 1;
    step();
    loc_wr_en = 0;
  endtask

  task automatic pulse_commit(input int b, input int len);
    loc_bank = b[0]; loc_len = 5'(len); loc_commit = 1;
    step();
    loc_commit = 0;
  endtask

  task automatic pulse_release(input int b);
    loc_bank = b[0]; loc_release = 1;
    step();
    loc_release = 0;
  endtask

  task automatic pulse_free(input int b);
    loc_bank = b[0]; loc_free = 1;
    step();
    loc_free = 0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    int ub;
    rst_n = 0; mode_tx = 0; hs_mode = 0;
    usb_wr_valid = 0; usb_wr_last = 0; usb_wr_data = 0;
    usb_rd_en = 0; usb_tx_done = 0;
    loc_bank = 0; loc_addr = 0; loc_wr_en = 0; loc_wdata = 0;
    loc_commit = 0; loc_len = 0; loc_release = 0; loc_free = 0;
    copy_start = 0;
    step(); step();
    rst_n = 1;
    step();

    // R1 reset state
    check("R1 bank_full", bank_full, 0);
    check("R1 usb_bank", usb_bank, 0);
    check("R1 rx_ready", usb_rx_ready, 1);
    check("R1 tx_avail", usb_tx_avail, 0);
    check("R1 cp_valid", cp_valid, 0);

    // vector table: received packets (R2, R4, R5)
    ub = 0;
    for (int k = 0; k < 6; k++) begin
      int len, base, bad;
      len  = int'(VEC[k][7:0]);
      bad  = int'(VEC[k][14]);
      base = k * 32 + 1;
      hs_mode = VEC[k][15];
      send_pkt(len, base);
      check(bad ? "R4 err pulse" : "R2 no err", usb_rx_err, bad);
      check(bad ? "R4 bank stays empty" : "R2 bank full", int'(bank_full[ub]), 1 - bad);
      loc_bank = ub[0];
      #1;
      check(bad ? "R4 count zero" : "R2 count", loc_count, bad ? 0 : len);
      if (bad) begin
        check("R4 pointer kept", usb_bank, ub);
        step();
        check("R4 err one cycle", usb_rx_err, 0);
      end else begin
        check("R2 pointer toggles", usb_bank, 1 - ub);
        for (int a = 0; a < len; a++) begin
          loc_addr = 4'(a);
          step();
          check("R2 readback", loc_rdata, (base + a) & 8'hFF);
        end
        pulse_free(ub);
        check("R5 freed", int'(bank_full[ub]), 0);
        loc_bank = ub[0];
        #1;
        check("R5 count cleared", loc_count, 0);
        ub = 1 - ub;
      end
    end

    // R3 both banks full: bytes dropped
    hs_mode = 0;
    send_pkt(4, 8'hA0);
    send_pkt(4, 8'hB0);
    check("R3 both full", bank_full, 3);
    check("R3 rx_ready low", usb_rx_ready, 0);
    send_pkt(3, 8'hC0);
    check("R3 no err", usb_rx_err, 0);
    loc_bank = ub[0]; loc_addr = 0;
    step();
    check("R3 count kept", loc_count, 4);
    check("R3 data kept", loc_rdata, 8'hA0);
    loc_bank = 1'(1 - ub); loc_addr = 0;
    step();
    check("R3 other count kept", loc_count, 4);
    check("R3 other data kept", loc_rdata, 8'hB0);
    pulse_free(ub);
    check("R5 reopened", usb_rx_ready, 1);
    pulse_free(1 - ub);

    // R10 flush with content held
    send_pkt(2, 8'h11);
    check("R10 precond full", int'(bank_full != 0), 1);
    mode_tx = 1;
    step();
    check("R10 flush full", bank_full, 0);
    check("R10 flush pointer", usb_bank, 0);
    check("R10 rx_ready low in tx", usb_rx_ready, 0);

    // R6 / R7 transmit ordering
    for (int i = 0; i < 5; i++) loc_write(0, i, 8'h50 + i);
    pulse_commit(0, 5);
    check("R6 committed full", int'(bank_full[0]), 1);
    check("R6 not offered before release", usb_tx_avail, 0);
    for (int i = 0; i < 3; i++) loc_write(1, i, 8'h60 + i);
    pulse_commit(1, 3);
    pulse_release(1);
    check("R7 bank1 released but not offered", usb_tx_avail, 0);
    pulse_release(0);
    check("R6 offered after release", usb_tx_avail, 1);
    check("R7 tx_len bank0", usb_tx_len, 5);
    for (int i = 0; i < 5; i++) begin
      usb_rd_en = 1;
      step();
      check("R7 tx byte bank0", usb_rd_data, 8'h50 + i);
    end
    usb_rd_en = 0;
    usb_tx_done = 1;
    step();
    usb_tx_done = 0;
    check("R7 bank0 emptied", int'(bank_full[0]), 0);
    check("R7 pointer to bank1", usb_bank, 1);
    check("R7 bank1 offered", usb_tx_avail, 1);
    check("R7 tx_len bank1", usb_tx_len, 3);
    for (int i = 0; i < 3; i++) begin
      usb_rd_en = 1;
      step();
      check("R7 tx byte bank1", usb_rd_data, 8'h60 + i);
    end
    usb_rd_en = 0;
    usb_tx_done = 1;
    step();
    usb_tx_done = 0;
    check("R7 pointer back to bank0", usb_bank, 0);
    check("R7 all empty", bank_full, 0);

    // R8 commit length limit
    hs_mode = 0;
    pulse_commit(0, 9);
    check("R8 over FS limit ignored", int'(bank_full[0]), 0);
    hs_mode = 1;
    pulse_commit(0, 9);
    check("R8 within HS limit", int'(bank_full[0]), 1);
    loc_bank = 0;
    #1;
    check("R8 count", loc_count, 9);

    // R11 copy stream from bank1
    pulse_commit(1, 3);
    loc_bank = 1; copy_start = 1;
    step();
    copy_start = 0;
    check("R11 not yet valid", cp_valid, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R11 valid", cp_valid, 1);
      check("R11 data", cp_data, 8'h60 + i);
      check("R11 last", cp_last, (i == 2) ? 1 : 0);
    end
    step();
    check("R11 stream ended", cp_valid, 0);

    // R10 release flags cleared by a direction round trip
    pulse_release(0);
    check("R10 precond offered", usb_tx_avail, 1);
    mode_tx = 0; step();
    mode_tx = 1; step();
    check("R10 round trip empty", bank_full, 0);
    pulse_commit(0, 2);
    check("R10 release dropped", usb_tx_avail, 0);

    // R9 release on an empty bank
    mode_tx = 0; step();
    mode_tx = 1; step();
    pulse_release(0);
    pulse_commit(0, 2);
    check("R9 early release ignored", usb_tx_avail, 0);
    pulse_release(0);
    check("R9 real release", usb_tx_avail, 1);

    done = 1;
    finish_run();
  end

endmodule